// File: doc/BRIEF.md
# Six-Flag Compare and Branch Unit

This block sits in the execute stage of a small core. A compare strobe evaluates the destination operand against the source operand as two's-complement signed numbers. All six relation flags are rewritten at once: greater-than, greater-or-equal, less-than, less-or-equal, equal and not-equal. A later conditional branch reads one of those flags. It then drives the next program counter with either the branch target or the already-incremented PC that the fetch stage supplies.

Flag state can be written from outside through a load port, so that a context switch can save the six flags and later put them back. Operand selection, whether a register or an immediate, is made upstream. Either operand port may carry an immediate, so the immediate-versus-register, register-versus-immediate and register-versus-register compare forms all arrive here as two plain values. The block holds no state machine: its only state is the six-bit flag register, which has three named update paths (reset, load, compare) plus hold.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, all six flags read 0 after the next clock edge. With no branch strobe, `next_pc` equals `pc_inc`.
- R2: A compare (`cmp_en` high at a rising edge) makes the flags visible on `flags` from that edge on, that is, one cycle after the strobe is sampled. The flag bit positions are GT=bit0 (dst>src), GTE=bit1 (dst>=src), LT=bit2 (dst<src), LTE=bit3 (dst<=src), EQ=bit4 (dst==src) and NEQ=bit5 (dst!=src). A compare strobe and a branch strobe are never high in the same cycle.
- R3: Every compare rewrites all six flags, so a flag set by an earlier compare is cleared whenever its relation does not hold for the new operands.
- R4: Operands are compared as signed two's-complement numbers of `DATA_W` bits. For example, dst = all-ones (−1) against src = 1 gives LT, LTE and NEQ.
- R5: With neither `cmp_en` nor `flag_ld_en` high, the flags keep their value, and a branch does not change them.
- R6: With `flag_ld_en` high at a rising edge, `flags` takes `flag_ld_val` from that edge on. A load takes priority over a compare in the same cycle.
- R7: With `br_en` low, `next_pc` equals `pc_inc`, whatever `br_kind` and the flags hold.
- R8: With `br_en` high and `br_kind` = 0 (unconditional), `next_pc` equals `br_target` for any flag state.
- R9: With `br_en` high, each conditional kind tests only its own flag: 1 uses NEQ, 2 uses EQ, 3 uses LT, 4 uses LTE, 5 uses GT and 6 uses GTE. `next_pc` is `br_target` when that flag is 1 and `pc_inc` when it is 0.
- R10: `br_kind` = 7 is a reserved kind that is never taken: `next_pc` equals `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_val | input | DATA_W | First (source) operand, signed |
| dst_val | input | DATA_W | Second (destination) operand, signed |
| cmp_en | input | 1 | Compare strobe |
| br_en | input | 1 | Branch strobe |
| br_kind | input | 3 | Branch kind code (0 unconditional, 1..6 conditional, 7 reserved) |
| br_target | input | PC_W | Branch target address |
| pc_inc | input | PC_W | Already-incremented program counter |
| flag_ld_en | input | 1 | Flag load enable (context restore) |
| flag_ld_val | input | 6 | Flag value to load |
| flags | output | 6 | Registered relation flags |
| next_pc | output | PC_W | Selected next program counter |

## Verification
The compare is driven with operand pairs that fall on each side of equality. These include positive pairs, negative pairs, mixed-sign pairs and the extreme values of the width, which separate a signed comparison from an unsigned one and a correct relation from one whose operands are swapped. After each compare, every branch kind is applied. This catches a kind wired to the wrong flag, and consecutive compares with different outcomes show that stale flags are cleared. Loading each single-flag pattern in turn and branching on all kinds isolates each kind's flag from the others. A load issued together with a compare shows which of the two wins.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    localparam int NFLAG  = 6;
    localparam int KIND_W = 3;

    // flag bit positions, decoded by the branch resolver
    localparam int FB_GT  = 0;
    localparam int FB_GTE = 1;
    localparam int FB_LT  = 2;
    localparam int FB_LTE = 3;
    localparam int FB_EQ  = 4;
    localparam int FB_NEQ = 5;

    typedef enum logic [KIND_W-1:0] {
        BK_ALWAYS = 3'd0,
        BK_NE     = 3'd1,
        BK_EQ     = 3'd2,
        BK_LT     = 3'd3,
        BK_LE     = 3'd4,
        BK_GT     = 3'd5,
        BK_GE     = 3'd6,
        BK_NEVER  = 3'd7
    } br_kind_e;

    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rel_compare.sv
module rel_compare
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic signed [DATA_W-1:0] src_val,
    input  logic signed [DATA_W-1:0] dst_val,
    output flag_vec_t                rel
);
    logic gt_w;
    logic eq_w;

    always_comb begin
        gt_w = (dst_val > src_val);
        eq_w = (dst_val == src_val);
        rel          = '0;
        rel[FB_GT]   = gt_w;
        rel[FB_GTE]  = gt_w | eq_w;
        rel[FB_LT]   = ~gt_w & ~eq_w;
        rel[FB_LTE]  = ~gt_w;
        rel[FB_EQ]   = eq_w;
        rel[FB_NEQ]  = ~eq_w;
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cbu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmp_en,
    input  logic      ld_en,
    input  flag_vec_t ld_val,
    input  flag_vec_t rel,
    output flag_vec_t flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (ld_en) begin
            flags <= ld_val;
        end else if (cmp_en) begin
            flags <= rel;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> flags == '0);

    assert_three_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !ld_en) |=> $countones(flags) == 3);

    assert_consistent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !ld_en) |=> (flags[FB_GTE] == (flags[FB_GT] | flags[FB_EQ]))
                            && (flags[FB_LTE] == (flags[FB_LT] | flags[FB_EQ]))
                            && (flags[FB_NEQ] == !flags[FB_EQ]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !ld_en) |=> $stable(flags));

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> flags == $past(ld_val));
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import cbu_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              br_en,
    input  logic [KIND_W-1:0] br_kind,
    input  flag_vec_t         flags,
    input  logic [PC_W-1:0]   br_target,
    input  logic [PC_W-1:0]   pc_inc,
    output logic [PC_W-1:0]   next_pc
);
    logic take;

    always_comb begin
        unique case (br_kind_e'(br_kind))
            BK_ALWAYS: take = 1'b1;
            BK_NE:     take = flags[FB_NEQ];
            BK_EQ:     take = flags[FB_EQ];
            BK_LT:     take = flags[FB_LT];
            BK_LE:     take = flags[FB_LTE];
            BK_GT:     take = flags[FB_GT];
            BK_GE:     take = flags[FB_GTE];
            BK_NEVER:  take = 1'b0;
            default:   take = 1'b0;
        endcase
        next_pc = (br_en && take) ? br_target : pc_inc;
    end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    input  logic              cmp_en,
    input  logic              br_en,
    input  logic [2:0]        br_kind,
    input  logic [PC_W-1:0]   br_target,
    input  logic [PC_W-1:0]   pc_inc,
    input  logic              flag_ld_en,
    input  logic [5:0]        flag_ld_val,
    output logic [5:0]        flags,
    output logic [PC_W-1:0]   next_pc
);
    flag_vec_t rel_w;
    flag_vec_t flags_q;

    rel_compare #(.DATA_W(DATA_W)) u_cmp (
        .src_val (src_val),
        .dst_val (dst_val),
        .rel     (rel_w)
    );

    flag_store u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_en (cmp_en),
        .ld_en  (flag_ld_en),
        .ld_val (flag_ld_val),
        .rel    (rel_w),
        .flags  (flags_q)
    );

    branch_resolve #(.PC_W(PC_W)) u_br (
        .br_en     (br_en),
        .br_kind   (br_kind),
        .flags     (flags_q),
        .br_target (br_target),
        .pc_inc    (pc_inc),
        .next_pc   (next_pc)
    );

    assign flags = flags_q;

    assert_cmp_br_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_en && br_en));

    assert_no_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> next_pc == pc_inc);

    assert_uncond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && br_kind == 3'd0) |-> next_pc == br_target);

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && br_kind == 3'd7) |-> next_pc == pc_inc);
endmodule

// File: tb/tb_cmp_branch_unit.sv
module tb_cmp_branch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int PW = 16;
    localparam int NVEC = 10;

    localparam logic [5:0] F_GTR = 6'h23;  // GT, GTE, NEQ
    localparam logic [5:0] F_LSS = 6'h2C;  // LT, LTE, NEQ
    localparam logic [5:0] F_EQU = 6'h1A;  // GTE, LTE, EQ

    // {src, dst, expected flags}
    localparam logic [69:0] VEC [NVEC] = '{
        {32'd5,          32'd9,          F_GTR},
        {32'd9,          32'd5,          F_LSS},
        {32'd7,          32'd7,          F_EQU},
        {32'd1,          32'hFFFF_FFFF,  F_LSS},
        {32'hFFFF_FFFF,  32'd1,          F_GTR},
        {32'h8000_0000,  32'h7FFF_FFFF,  F_GTR},
        {32'h7FFF_FFFF,  32'h8000_0000,  F_LSS},
        {32'd0,          32'd0,          F_EQU},
        {32'hFFFF_FFFB,  32'hFFFF_FFFD,  F_GTR},
        {32'h8000_0000,  32'h8000_0000,  F_EQU}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] src_val = '0;
    logic [DW-1:0] dst_val = '0;
    logic          cmp_en = 1'b0;
    logic          br_en = 1'b0;
    logic [2:0]    br_kind = '0;
    logic [PW-1:0] br_target = '0;
    logic [PW-1:0] pc_inc = '0;
    logic          flag_ld_en = 1'b0;
    logic [5:0]    flag_ld_val = '0;
    logic [5:0]    flags;
    logic [PW-1:0] next_pc;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_branch_unit #(.DATA_W(DW), .PC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .src_val(src_val), .dst_val(dst_val),
        .cmp_en(cmp_en), .br_en(br_en), .br_kind(br_kind),
        .br_target(br_target), .pc_inc(pc_inc), .flag_ld_en(flag_ld_en),
        .flag_ld_val(flag_ld_val), .flags(flags), .next_pc(next_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // flag bit tested by each conditional kind (R9 map)
    function automatic bit kind_taken(input logic [2:0] k, input logic [5:0] f);
        case (k)
            3'd0: return 1'b1;
            3'd1: return f[5];
            3'd2: return f[4];
            3'd3: return f[2];
            3'd4: return f[3];
            3'd5: return f[0];
            3'd6: return f[1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_cmp(input logic [DW-1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        src_val = s; dst_val = d; cmp_en = 1'b1;
        @(negedge clk);
        cmp_en = 1'b0;
        #1;
    endtask

    task automatic do_load(input logic [5:0] v, input bit with_cmp);
        @(negedge clk);
        flag_ld_val = v; flag_ld_en = 1'b1; cmp_en = with_cmp;
        @(negedge clk);
        flag_ld_en = 1'b0; cmp_en = 1'b0;
        #1;
    endtask

    task automatic try_all_kinds(input logic [5:0] f, input string tag);
        for (int k = 0; k < 8; k++) begin
            br_kind = 3'(k);
            br_target = 16'hA000 + 16'(k);
            pc_inc = 16'h0100 + 16'(k);
            br_en = 1'b1;
            #1;
            if (k == 0)
                check({tag, " R8 uncond"}, 32'(next_pc), 32'(br_target));
            else if (k == 7)
                check({tag, " R10 reserved"}, 32'(next_pc), 32'(pc_inc));
            else
                check({tag, " R9 cond"}, 32'(next_pc),
                      kind_taken(3'(k), f) ? 32'(br_target) : 32'(pc_inc));
            br_en = 1'b0;
            #1;
            check({tag, " R7 no strobe"}, 32'(next_pc), 32'(pc_inc));
        end
        check({tag, " R5 branch keeps flags"}, 32'(flags), 32'(f));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset flags", 32'(flags), 32'h0);
        pc_inc = 16'h0042;
        #1;
        check("R1 reset next_pc", 32'(next_pc), 32'h42);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R2, R3, R4 plus all kinds
        for (int i = 0; i < NVEC; i++) begin
            do_cmp(VEC[i][69:38], VEC[i][37:6]);
            check($sformatf("R2 R4 vec%0d flags", i), 32'(flags), 32'(VEC[i][5:0]));
            try_all_kinds(VEC[i][5:0], $sformatf("vec%0d", i));
        end

        // R3: greater then equal clears GT and NEQ
        do_cmp(32'd1, 32'd2);
        check("R3 pre", 32'(flags), 32'(F_GTR));
        do_cmp(32'd3, 32'd3);
        check("R3 stale cleared", 32'(flags), 32'(F_EQU));

        // R5: idle cycles hold
        repeat (3) @(negedge clk);
        #1;
        check("R5 hold idle", 32'(flags), 32'(F_EQU));

        // R6: load, then load beats compare
        do_load(6'h15, 1'b0);
        check("R6 load", 32'(flags), 32'h15);
        src_val = 32'd0; dst_val = 32'd9;
        do_load(6'h08, 1'b1);
        check("R6 load over compare", 32'(flags), 32'h08);

        // R9: each single flag isolated
        for (int b = 0; b < 6; b++) begin
            do_load(6'(1 << b), 1'b0);
            check($sformatf("R6 single bit %0d", b), 32'(flags), 32'(1 << b));
            try_all_kinds(6'(1 << b), $sformatf("bit%0d", b));
        end
        do_load(6'h00, 1'b0);
        try_all_kinds(6'h00, "none");
        do_load(6'h3F, 1'b0);
        try_all_kinds(6'h3F, "all");

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset mid-run", 32'(flags), 32'h0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule